// File: doc/BRIEF.md
# Haptic Phase Timer Tick Generator

This block produces the base tick used to time the phases of a haptic drive sequence. It takes its time base from one of two sources: an internal pulse that arrives once per millisecond, or an external clock pin. The selected pulses then pass through a divider. Three cascaded divide stages, worth 2, 4 and 16, can each be enabled, so the overall ratio is any power of two from 1 to 128. The block emits one single-cycle tick for every complete group of source pulses.

When the external pin is the time base, a watchdog measures the time between successive rising edges of that pin. If no new edge arrives within a programmable number of system clocks, the block emits a one-cycle fault pulse, which the sequencer uses to abort a running haptic pattern. The external pin is synchronized with a two-flop chain, and only its rising edges are counted. Any change of the configuration clears the divider, so a change never produces a tick that comes from a mix of the old and new settings.

Top module: `tmr_tick_gen`

## Requirements
- R1: cfgBits[0] selects the source. With 0 the block counts intTick pulses and ignores extClkPin. With 1 it counts rising edges of extClkPin and ignores intTick.
- R2: cfgBits[1], cfgBits[2] and cfgBits[3] enable divide stages of 2, 4 and 16. The ratio is the product of the enabled stages (1 to 128), and timerTick fires on every ratio-th counted source pulse, starting from a cleared divider.
- R3: timerTick is high for exactly one clock. With the internal source and ratio 1, it is high in the cycle after the cycle in which intTick is high.
- R4: extClkPin passes through two synchronizing flops, and each rising edge counts once, however long the pin stays high.
- R5: Any change of cfgBits clears the divider and suppresses the tick in the following cycle. After a change, the first tick needs a full ratio of new source pulses.
- R6: The watchdog runs only while cfgBits[0] is 1. With the internal source, wdogFault stays low.
- R7: While cfgBits[0] is 1, if WDOG_LIMIT system clocks pass with no synchronized rising edge of extClkPin, wdogFault pulses high for one clock. It does not pulse again until a new edge restarts the count.
- R8: Each synchronized rising edge of extClkPin restarts the watchdog count. An external clock whose period is shorter than WDOG_LIMIT clocks never raises wdogFault.
- R9: While rstN is low, timerTick and wdogFault are low and the divider and watchdog are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| extClkPin | input | 1 | External time-base pin, asynchronous |
| intTick | input | 1 | Internal 1 ms pulse, one clock wide, synchronous to clk |
| cfgBits | input | 4 | Bit 0 selects the source; bits 1 to 3 enable divide by 2, 4 and 16 |
| timerTick | output | 1 | One-cycle divided timer tick |
| wdogFault | output | 1 | One-cycle external-clock stall pulse |

## Verification
The assertions assume that intTick is a pulse one clock wide, synchronous to clk and never high in two consecutive cycles. They also assume that cfgBits changes only on clock edges. The stimulus drives intTick as isolated single-cycle pulses with idle cycles between them. It holds each extClkPin level for several clocks, so the synchronizer sees every edge. It changes cfgBits only while no source pulse is in flight.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DIV_EXP_MAX = 7;            // 2*4*16 = 2**7
  localparam int DIV_W       = DIV_EXP_MAX;  // counter holds 0..127

  typedef struct packed {
    logic srcPulse;     // one counted time-base pulse
    logic clrDiv;       // clear divider (configuration changed)
    logic wdogRun;      // watchdog enabled this cycle
    logic wdogRestart;  // external edge seen, restart watchdog
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             extRise,
  input  logic             intTick,
  input  logic [3:0]       cfgBits,
  output tmrStrobe_t       strobe,
  output logic [DIV_W-1:0] ratioM1
);
  logic [3:0] cfgPrev;
  logic       cfgChg;
  logic       cfgExt;
  logic [2:0] divExp;

  always_ff @(posedge clk) begin
    if (!rstN) cfgPrev <= 4'd0;
    else       cfgPrev <= cfgBits;
  end

  assign cfgChg = (cfgBits != cfgPrev);
  assign cfgExt = cfgBits[0];
  // stage weights 2,4,16 are 2**1, 2**2, 2**4
  assign divExp  = cfgBits[3:1];
  assign ratioM1 = DIV_W'((8'd1 << divExp) - 8'd1);

  always_comb begin
    strobe.srcPulse    = cfgExt ? extRise : intTick;
    strobe.clrDiv      = cfgChg;
    strobe.wdogRun     = cfgExt && !cfgChg;
    strobe.wdogRestart = extRise;
  end

  a_r5_chg_clears: assert property (@(posedge clk) disable iff (!rstN)
    cfgChg |-> strobe.clrDiv && !strobe.wdogRun);
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int WDOG_LIMIT  = 8000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extClkPin,
  input  tmrStrobe_t       strobe,
  input  logic [DIV_W-1:0] ratioM1,
  output logic             extRise,
  output logic             timerTick,
  output logic             wdogFault
);
  localparam int WD_W = $clog2(WDOG_LIMIT + 1);
  localparam logic [WD_W-1:0] WD_TOP  = WD_W'(WDOG_LIMIT);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WDOG_LIMIT - 1);

  logic [SYNC_STAGES:0] syncQ;
  logic [DIV_W-1:0]     divCnt;
  logic [WD_W-1:0]      wdCnt;

  // synchronizer chain plus one history flop for edge detection
  genvar gi;
  generate
    for (gi = 0; gi <= SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[gi] <= 1'b0;
        else if (gi == 0) syncQ[gi] <= extClkPin;
        else syncQ[gi] <= syncQ[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  assign extRise = syncQ[SYNC_STAGES-1] && !syncQ[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      timerTick <= 1'b0;
    end else if (strobe.clrDiv) begin
      divCnt    <= '0;
      timerTick <= 1'b0;
    end else if (strobe.srcPulse) begin
      if (divCnt >= ratioM1) begin
        divCnt    <= '0;
        timerTick <= 1'b1;
      end else begin
        divCnt    <= divCnt + 1'b1;
        timerTick <= 1'b0;
      end
    end else begin
      timerTick <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.wdogRun || strobe.wdogRestart) begin
      wdCnt     <= '0;
      wdogFault <= 1'b0;
    end else if (wdCnt == WD_LAST) begin
      wdCnt     <= WD_TOP;
      wdogFault <= 1'b1;
    end else begin
      if (wdCnt != WD_TOP) wdCnt <= wdCnt + 1'b1;
      wdogFault <= 1'b0;
    end
  end

  a_r7_fault_single: assert property (@(posedge clk) disable iff (!rstN)
    wdogFault |=> !wdogFault);
  a_r8_edge_no_fault: assert property (@(posedge clk) disable iff (!rstN)
    extRise |=> !wdogFault);
  a_r4_rise_single: assert property (@(posedge clk) disable iff (!rstN)
    extRise |=> !extRise);
  a_r2_div_bound: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrDiv |=> divCnt <= $past(ratioM1));
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
#(
  parameter int WDOG_LIMIT = 8000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extClkPin,
  input  logic       intTick,
  input  logic [3:0] cfgBits,
  output logic       timerTick,
  output logic       wdogFault
);
  tmrStrobe_t       strobe;
  logic [DIV_W-1:0] ratioM1;
  logic             extRise;

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .extRise(extRise), .intTick(intTick),
    .cfgBits(cfgBits), .strobe(strobe), .ratioM1(ratioM1)
  );

  tmr_dp #(.WDOG_LIMIT(WDOG_LIMIT), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .extClkPin(extClkPin), .strobe(strobe),
    .ratioM1(ratioM1), .extRise(extRise), .timerTick(timerTick),
    .wdogFault(wdogFault)
  );

  a_r6_int_no_fault: assert property (@(posedge clk) disable iff (!rstN)
    !cfgBits[0] |=> !wdogFault);
  a_r1_int_idle_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgBits[0] && !intTick) |=> !timerTick);
  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rstN)
    timerTick |=> !timerTick);
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !timerTick && !wdogFault);
endmodule

// File: tb/tmr_tick_gen_tb.sv
module tmr_tick_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 40;

  logic clk = 1'b0, rstN = 1'b0, extClkPin = 1'b0, intTick = 1'b0;
  logic [3:0] cfgBits = 4'd0;
  logic timerTick, wdogFault;

  int checks = 0, errors = 0;
  int tickCnt = 0, faultCnt = 0, widthErr = 0, cyc = 0;
  int lastRiseCyc = 0, faultCyc = 0;
  logic prevTick = 1'b0;

  tmr_tick_gen #(.WDOG_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rstN(rstN), .extClkPin(extClkPin), .intTick(intTick),
    .cfgBits(cfgBits), .timerTick(timerTick), .wdogFault(wdogFault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (timerTick) tickCnt++;
      if (timerTick && prevTick) widthErr++;
      if (wdogFault) begin faultCnt++; faultCyc = cyc; end
    end
    prevTick = timerTick;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic intPulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) intTick = 1'b1;
      @(negedge clk) intTick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic extPulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin extClkPin = 1'b1; lastRiseCyc = cyc; end
      repeat (3) @(negedge clk);
      extClkPin = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic setCfg(input logic [3:0] v);
    @(negedge clk) cfgBits = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic int ratioOf(input logic [3:0] c);
    return (c[1] ? 2 : 1) * (c[2] ? 4 : 1) * (c[3] ? 16 : 1);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset tick", int'(timerTick), 0);
    check("R9 reset fault", int'(wdogFault), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3 latency and width, internal source, ratio 1
    @(negedge clk) intTick = 1'b1;
    @(negedge clk) begin intTick = 1'b0; check("R3 tick next cycle", int'(timerTick), 1); end
    @(negedge clk) check("R3 tick one cycle", int'(timerTick), 0);

    // R1/R2 sweep over both sources and all divide settings
    for (int src = 0; src < 2; src++) begin
      for (int d = 0; d < 8; d++) begin
        logic [3:0] c;
        int r;
        c = {d[2:0], src[0]};
        r = ratioOf(c);
        setCfg(c);
        tickCnt = 0;
        if (src == 0) intPulses(3 * r - 1); else extPulses(3 * r - 1);
        check($sformatf("R2 src%0d div%0d partial", src, d), tickCnt, 2);
        if (src == 0) intPulses(1); else extPulses(1);
        check($sformatf("R2 src%0d div%0d full", src, d), tickCnt, 3);
      end
    end

    // R1 ignored source
    setCfg(4'b0000); tickCnt = 0;
    extPulses(4);
    check("R1 ext ignored when internal", tickCnt, 0);
    setCfg(4'b0001); tickCnt = 0;
    intPulses(4);
    check("R1 int ignored when external", tickCnt, 0);

    // R4 long high pin counts once
    tickCnt = 0;
    @(negedge clk) extClkPin = 1'b1;
    repeat (20) @(negedge clk);
    extClkPin = 1'b0;
    repeat (5) @(negedge clk);
    check("R4 long high one edge", tickCnt, 1);

    // R5 configuration change clears divider
    setCfg(4'b0110); tickCnt = 0;
    intPulses(5);
    check("R5 ratio8 partial", tickCnt, 0);
    setCfg(4'b0010);
    intPulses(1);
    check("R5 first pulse after change", tickCnt, 0);
    intPulses(1);
    check("R5 full new ratio", tickCnt, 1);

    // R6 no fault with internal source
    faultCnt = 0;
    repeat (4 * LIMIT) @(negedge clk);
    check("R6 internal no fault", faultCnt, 0);

    // R8 running external clock keeps watchdog quiet
    setCfg(4'b0001); faultCnt = 0;
    extPulses(30);
    check("R8 running clock no fault", faultCnt, 0);

    // R7 stall raises exactly one pulse, at the timeout
    repeat (3 * LIMIT) @(negedge clk);
    check("R7 single fault on stall", faultCnt, 1);
    check("R7 timeout window", int'((faultCyc - lastRiseCyc) >= LIMIT &&
                                    (faultCyc - lastRiseCyc) <= LIMIT + 5), 1);
    extPulses(1);
    repeat (3 * LIMIT) @(negedge clk);
    check("R7 rearm after edge", faultCnt, 2);

    check("R3 tick width", widthErr, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule